// File: doc/BRIEF.md
# Latched Edge-Detect Status Register

This block watches six external pins (receive clock, transmit clock, receive request, transmit request, carrier detect and clear-to-send) and four internal single-cycle event inputs. Every pin is brought into the clock domain by a two-flop synchronizer. It has a separate enable for its rising edge and for its falling edge. Each internal event has one enable. When an enabled transition is seen, the source's flag is latched. For a pin, the reported level is frozen next to the flag, so that software sees the level that caused the event.

Software reaches two 16-bit registers over a plain register bus: an enable register at address 0 and a status register at address 1. A flag is acknowledged by writing 1 to it. The flag then drops for one cycle and, for that moment, the level bit shows the live pin. If an enabled edge arrived while the flag was held, including in the same cycle as the acknowledge, the flag sets itself again on the next clock. The interrupt request is the OR of all flags.

Top module: `edge_latch_stat`

## Requirements
- R1: After synchronous reset, both registers read 0 and irq_o is low. irq_o is also held low while rst is high.
- R2: A write with addr_i=0 loads all 16 bits of the enable register, and a read with addr_i=0 returns it. For pin p (0=clear-to-send, 1=carrier detect, 2=transmit request, 3=receive request, 4=transmit clock, 5=receive clock), bit 5+2p enables rising edges and bit 4+2p enables falling edges. Bits 3..0 enable internal events 3..0.
- R3: With the rising enable set, a 0-to-1 change on pin p sets status flag bit 4+2p within four clock cycles. Without that enable, the rise sets no flag.
- R4: With the falling enable set, a 1-to-0 change on pin p sets flag bit 4+2p. Without that enable, the fall sets no flag.
- R5: Status bit 5+2p reports the synchronized level of pin p while flag 4+2p is 0. While the flag is 1, bit 5+2p holds the level latched when the flag set.
- R6: A status write (addr_i=1) with bit 4+2p (or bit k<4) at 1 clears that flag at the write edge. Immediately after that edge, the level bit shows the live synchronized pin.
- R7: If an enabled edge occurred while a flag was 1, an acknowledge leaves the flag at 0 for exactly one cycle, after which it is 1 again with the level frozen anew.
- R8: Writing 0 to a flag bit leaves it unchanged. Values written to level bits (odd bits 15..5) have no effect.
- R9: A one-cycle pulse on evt_i[k] with enable bit k set sets status bit k at the next clock. With the enable clear, the pulse has no effect.
- R10: irq_o is 1 exactly when at least one status flag (bits 14,12,10,8,6,4,3..0) is 1.
- R11: An enabled event arriving in the same cycle as the acknowledge of its flag is kept. The flag reads 0 right after the write and 1 one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | 6 | Asynchronous external pins, index p as listed in R2 |
| evt_i | input | 4 | Synchronous single-cycle internal events |
| addr_i | input | 1 | Register select: 0 enable, 1 status |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sweeps every pin through all four enable combinations, driving a rise and then a fall. This would catch an up/down enable swap, a wrong bit position, or a pin wired to the wrong pair. It acknowledges a flag after a second edge has been held back and samples the status right after the write edge and again one clock later. A design that re-arms the flag without the one-cycle gap would fail here, and so would one that shows the stale frozen level in the gap or loses the held edge. An event coincident with its own acknowledge is checked to survive, and writes of 0 to flags and 1 to level bits are checked to leave the status word unchanged.

// File: rtl/edge_latch_pkg.sv
package edge_latch_pkg;

    typedef enum logic {
        SEL_ENABLE = 1'b0,
        SEL_STATUS = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic flag;
        logic pend;
    } src_state_t;

    // Status/enable bit of a source's flag: events first, then pin pairs.
    function automatic int flag_pos(input int src, input int num_evt);
        return (src < num_evt) ? src : num_evt + 2 * (src - num_evt);
    endfunction

    function automatic int level_pos(input int src, input int num_evt);
        return flag_pos(src, num_evt) + 1;
    endfunction

endpackage

// File: rtl/el_sync.sv
module el_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] chain [STAGES];
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d_i;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[g] <= '0;
            else     chain[g] <= chain[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= chain[STAGES-1];
    end

    assign q_o    = chain[STAGES-1];
    assign rise_o = chain[STAGES-1] & ~prev_q;
    assign fall_o = ~chain[STAGES-1] & prev_q;
endmodule

// File: rtl/el_cell.sv
module el_cell
    import edge_latch_pkg::*;
#(
    parameter bit HAS_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic hit_i,
    input  logic ack_i,
    input  logic live_i,
    output logic flag_o,
    output logic pend_o,
    output logic level_o
);
    src_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (ack_i) begin
            st_q.flag <= 1'b0;
            st_q.pend <= st_q.pend | hit_i;
        end else if (st_q.flag) begin
            st_q.pend <= st_q.pend | hit_i;
        end else begin
            st_q.flag <= st_q.pend | hit_i;
            st_q.pend <= 1'b0;
        end
    end

    assign flag_o = st_q.flag;
    assign pend_o = st_q.pend;

    if (HAS_LEVEL) begin : g_level
        logic lvl_q;
        always_ff @(posedge clk) begin
            if (rst)              lvl_q <= 1'b0;
            else if (!st_q.flag)  lvl_q <= live_i;
        end
        assign level_o = st_q.flag ? lvl_q : live_i;
    end else begin : g_nolevel
        assign level_o = 1'b0;
    end
endmodule

// File: rtl/edge_latch_stat.sv
module edge_latch_stat
    import edge_latch_pkg::*;
#(
    parameter int NUM_PINS    = 6,
    parameter int NUM_EVT     = 4,
    parameter int SYNC_STAGES = 2,
    localparam int REG_W      = NUM_EVT + 2 * NUM_PINS,
    localparam int NSRC       = NUM_EVT + NUM_PINS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic [NUM_EVT-1:0]  evt_i,
    input  logic                addr_i,
    input  logic                wr_i,
    input  logic [REG_W-1:0]    wdata_i,
    output logic [REG_W-1:0]    rdata_o,
    output logic                irq_o
);
    logic [NUM_PINS-1:0] pin_s, pin_rise, pin_fall;
    logic [REG_W-1:0]    en_q;
    logic [REG_W-1:0]    stat_vec;
    logic [NSRC-1:0]     flag_vec, pend_vec, hit_vec, ack_vec;
    logic                stat_wr;

    el_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d_i    (pins_i),
        .q_o    (pin_s),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    always_ff @(posedge clk) begin
        if (rst)                                  en_q <= '0;
        else if (wr_i && addr_i == SEL_ENABLE)    en_q <= wdata_i;
    end

    assign stat_wr = wr_i && (addr_i == SEL_STATUS);

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        localparam int FP = flag_pos(s, NUM_EVT);
        assign ack_vec[s] = stat_wr && wdata_i[FP];
        if (s < NUM_EVT) begin : g_evt
            logic unused_lvl;
            assign hit_vec[s] = evt_i[s] & en_q[FP];
            el_cell #(.HAS_LEVEL(1'b0)) u_cell (
                .clk     (clk),
                .rst     (rst),
                .hit_i   (hit_vec[s]),
                .ack_i   (ack_vec[s]),
                .live_i  (1'b0),
                .flag_o  (flag_vec[s]),
                .pend_o  (pend_vec[s]),
                .level_o (unused_lvl)
            );
            assign stat_vec[FP] = flag_vec[s];
        end else begin : g_pin
            localparam int P = s - NUM_EVT;
            assign hit_vec[s] = (pin_rise[P] & en_q[FP+1])
                              | (pin_fall[P] & en_q[FP]);
            el_cell #(.HAS_LEVEL(1'b1)) u_cell (
                .clk     (clk),
                .rst     (rst),
                .hit_i   (hit_vec[s]),
                .ack_i   (ack_vec[s]),
                .live_i  (pin_s[P]),
                .flag_o  (flag_vec[s]),
                .pend_o  (pend_vec[s]),
                .level_o (stat_vec[FP+1])
            );
            assign stat_vec[FP] = flag_vec[s];
        end
    end

    assign rdata_o = (addr_i == SEL_STATUS) ? stat_vec : en_q;
    assign irq_o   = (|flag_vec) & ~rst;
endmodule

// File: rtl/el_checker.sv
module el_checker
    import edge_latch_pkg::*;
#(
    parameter int NUM_EVT = 4,
    parameter int NSRC    = 10,
    parameter int REG_W   = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             addr_i,
    input logic             wr_i,
    input logic [REG_W-1:0] wdata_i,
    input logic             irq_o,
    input logic [NSRC-1:0]  flag_vec,
    input logic [NSRC-1:0]  pend_vec,
    input logic [REG_W-1:0] stat_vec,
    input logic [REG_W-1:0] en_q
);
    logic rst_q;
    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q === 1'b1 && rst === 1'b0) begin
            p_reset_clear_r1: assert (flag_vec == '0 && en_q == '0 && pend_vec == '0)
                else $error("R1 state not cleared by reset");
        end
    end

    // R10: irq only falls when software writes the status register
    p_irq_fall_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_o) |-> $past(wr_i && addr_i == SEL_STATUS));

    for (genvar s = 0; s < NSRC; s++) begin : g_chk
        localparam int FP = flag_pos(s, NUM_EVT);
        logic ack;
        assign ack = wr_i && addr_i == SEL_STATUS && wdata_i[FP];

        p_ack_clears_r6: assert property (@(posedge clk) disable iff (rst)
            ack |=> !flag_vec[s]);

        p_write0_keeps_r8: assert property (@(posedge clk) disable iff (rst)
            (flag_vec[s] && !ack) |=> flag_vec[s]);

        p_relatch_r7: assert property (@(posedge clk) disable iff (rst)
            (pend_vec[s] && ack) ##1 !ack |=> flag_vec[s]);

        if (s >= NUM_EVT) begin : g_lvl
            p_level_frozen_r5: assert property (@(posedge clk) disable iff (rst)
                (flag_vec[s] && $past(flag_vec[s])) |-> $stable(stat_vec[FP+1]));
        end
    end
endmodule

bind edge_latch_stat el_checker #(
    .NUM_EVT (NUM_EVT),
    .NSRC    (NSRC),
    .REG_W   (REG_W)
) u_el_checker (
    .clk      (clk),
    .rst      (rst),
    .addr_i   (addr_i),
    .wr_i     (wr_i),
    .wdata_i  (wdata_i),
    .irq_o    (irq_o),
    .flag_vec (flag_vec),
    .pend_vec (pend_vec),
    .stat_vec (stat_vec),
    .en_q     (en_q)
);

// File: tb/tb_edge_latch_stat.sv
`timescale 1ns/1ps
module tb_edge_latch_stat;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  pins_i = '0;
    logic [3:0]  evt_i = '0;
    logic        addr_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [15:0] wdata_i = '0;
    logic [15:0] rdata_o;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    edge_latch_stat dut (
        .clk(clk), .rst(rst), .pins_i(pins_i), .evt_i(evt_i),
        .addr_i(addr_i), .wr_i(wr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .irq_o(irq_o)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wreg(input logic a, input logic [15:0] d);
        addr_i = a; wdata_i = d; wr_i = 1'b1;
        tick(1);
        wr_i = 1'b0; wdata_i = '0;
    endtask

    task automatic rstat(output logic [15:0] v);
        addr_i = 1'b1; #0.1; v = rdata_o;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, ref_v;
        tick(3);
        check("R1 irq in reset", {15'd0, irq_o}, 16'd0);
        rst = 1'b0;
        tick(1);
        addr_i = 1'b0; #0.1; check("R1 enable", rdata_o, 16'h0000);
        rstat(v); check("R1 status", v, 16'h0000);
        check("R1 irq", {15'd0, irq_o}, 16'd0);

        // R2 readback
        wreg(1'b0, 16'h1234);
        addr_i = 1'b0; #0.1; check("R2 enable readback", rdata_o, 16'h1234);

        // R3/R4/R10 sweep: every pin, every enable combination
        for (int p = 0; p < 6; p++) begin
            for (int m = 0; m < 4; m++) begin
                logic up, dn;
                up = m[1]; dn = m[0];
                wreg(1'b0, (16'(up) << (5 + 2*p)) | (16'(dn) << (4 + 2*p)));
                wreg(1'b1, 16'hFFFF); tick(1);
                pins_i[p] = 1'b1; tick(4);
                rstat(v);
                check("R3 rise", v, (16'd1 << (5 + 2*p)) | (16'(up) << (4 + 2*p)));
                check("R10 irq after rise", {15'd0, irq_o}, {15'd0, up});
                wreg(1'b1, 16'hFFFF); tick(1);
                pins_i[p] = 1'b0; tick(4);
                rstat(v);
                check("R4 fall", v, 16'(dn) << (4 + 2*p));
                check("R10 irq after fall", {15'd0, irq_o}, {15'd0, dn});
                wreg(1'b1, 16'hFFFF); tick(2);
            end
        end

        // R5/R6/R7 on pin 3 (bits 11/10)
        wreg(1'b0, 16'h0C00);
        pins_i[3] = 1'b1; tick(4);
        rstat(v); check("R5 latched high", v, 16'h0C00);
        pins_i[3] = 1'b0; tick(4);
        rstat(v); check("R5 level frozen", v, 16'h0C00);
        addr_i = 1'b1; wdata_i = 16'h0400; wr_i = 1'b1;
        tick(1);
        rstat(v); wr_i = 1'b0; wdata_i = '0;
        check("R6 cleared, live level", v, 16'h0000);
        tick(1);
        rstat(v); check("R7 re-latched", v, 16'h0400);
        check("R10 irq re-latched", {15'd0, irq_o}, 16'd1);
        pins_i[3] = 1'b1; tick(4);
        rstat(v); check("R5 frozen low", v, 16'h0400);
        wreg(1'b1, 16'h0400); rstat(v); check("R6 live high", v, 16'h0800);
        tick(1); rstat(v); check("R7 relatch on held rise", v, 16'h0C00);
        wreg(1'b1, 16'h0400); tick(2);
        rstat(v); check("R6 stays clear", v, 16'h0800);
        check("R10 irq clear", {15'd0, irq_o}, 16'd0);

        // R8: flag set, write zeros to flags and ones to level bits
        pins_i[3] = 1'b0; tick(4);
        rstat(v); ref_v = 16'h0400;
        check("R8 setup", v, ref_v);
        wreg(1'b1, 16'hAAA0); rstat(v); check("R8 level write ignored", v, ref_v);
        wreg(1'b1, 16'h0000); tick(1); rstat(v); check("R8 write0 no effect", v, ref_v);
        wreg(1'b1, 16'hFFFF); tick(2);

        // R9: internal events with and without enable
        for (int k = 0; k < 4; k++) begin
            for (int e = 0; e < 2; e++) begin
                wreg(1'b0, 16'(e) << k);
                evt_i[k] = 1'b1; tick(1); evt_i[k] = 1'b0;
                rstat(v); check("R9 event", v, 16'(e) << k);
                check("R10 irq event", {15'd0, irq_o}, {15'd0, e[0]});
                wreg(1'b1, 16'h000F); tick(1);
            end
        end

        // R11: event coincident with its acknowledge
        wreg(1'b0, 16'h0004);
        evt_i[2] = 1'b1; tick(1); evt_i[2] = 1'b0;
        rstat(v); check("R11 setup", v, 16'h0004);
        addr_i = 1'b1; wdata_i = 16'h0004; wr_i = 1'b1; evt_i[2] = 1'b1;
        tick(1);
        wr_i = 1'b0; wdata_i = '0; evt_i[2] = 1'b0;
        rstat(v); check("R11 cleared", v, 16'h0000);
        tick(1); rstat(v); check("R11 kept", v, 16'h0004);

        // R1 again: reset mid-run
        rst = 1'b1; tick(1);
        check("R1 irq held low", {15'd0, irq_o}, 16'd0);
        tick(1); rst = 1'b0; tick(1);
        rstat(v); check("R1 status after reset", v, 16'h0000);
        addr_i = 1'b0; #0.1; check("R1 enable after reset", rdata_o, 16'h0000);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule